// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the state changes a 64-bit processor's system control unit makes when it takes an exception. The pipeline raises a one-cycle request and supplies four things with it: a compact cause number, the program counter of the faulting instruction, a flag saying the instruction sits in a branch delay slot, and the faulting virtual address. On the next clock edge the block updates several pieces of state. It records the return address, and fills in the cause register's delay flag and exception code. It sets the exception-level bit in the status register and captures the bad address for address errors. It also produces the vector address at which the handler must be fetched.

The cause and status registers can also be written by software through a simple write strobe. The block applies a fixed mask of implemented fields, and bits outside those fields always read as zero. A nested exception, one taken while the exception level is already set, keeps the original return address and delay flag. It does not use the refill vector.

Top module: `cp0_exc_entry`

## Requirements
- R1: After reset, status reads 0x00400004 (boot-vector bit 22 and error-level bit 2 set, exception level bit 1 clear). Cause, return address, bad address and vector are all zero, and `vec_valid` is low.
- R2: The input `exc_cause` selects the exception kind, and cause bits 6..2 are set to that kind's exception code. The mapping is: 0 interrupt→0x00, 1 modify→0x01, 2 translation load→0x02, 3 translation store→0x03, 4 address error load→0x04, 5 address error store→0x05, 6 syscall→0x08, 7 breakpoint→0x09, 8 reserved instruction→0x0A, 9 unit unusable→0x0B, 10 overflow→0x0C, 11 trap→0x0D, 12 second coprocessor→0x12, 13 refill load→0x02, 14 refill store→0x03, 15→0x0A.
- R3: Consider a request taken while status bit 1 is clear. If the instruction is in a delay slot, the return address becomes PC−4 and cause bit 31 becomes 1. Otherwise the return address becomes PC and cause bit 31 becomes 0.
- R4: A request taken while status bit 1 is set leaves the return address and cause bit 31 unchanged. The exception code and vector are still updated.
- R5: Every request sets status bit 1, and no other status bit changes.
- R6: The vector offset is 0x080 only for causes 13 and 14 taken with status bit 1 clear. In every other case it is 0x180.
- R7: The vector is the base plus the offset. The base is 0xFFFFFFFFBFC00200 when status bit 22 is 1 and 0xFFFFFFFF80000000 when it is 0. `vec_valid` is high for exactly the cycle after each request.
- R8: Causes 4 and 5 load `exc_badaddr` into the bad-address register. No other request and no idle cycle changes that register.
- R9: A software write stores `sw_wdata` masked with 0xB0C0FF7C into cause or with 0xF040FFFF into status. Bits outside the mask read as zero.
- R10: When a request and a software write fall in the same cycle, the write is discarded and only the exception update takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request strobe |
| exc_cause | input | 4 | Exception kind (see R2) |
| exc_pc | input | 64 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a delay slot |
| exc_badaddr | input | 64 | Faulting virtual address |
| sw_we_cause | input | 1 | Software write to cause |
| sw_we_status | input | 1 | Software write to status |
| sw_wdata | input | 32 | Software write data |
| cause_q | output | 32 | Cause register |
| status_q | output | 32 | Status register |
| epc_q | output | 64 | Return address register |
| badvaddr_q | output | 64 | Bad virtual address register |
| vec_pc | output | 64 | Handler vector address |
| vec_valid | output | 1 | Vector valid, one cycle after a request |

## Verification
The assertions check the per-cycle rules on every cycle. These are: exception level set after every request, the held return address and delay flag on nested entry, the delay-slot return address, the one-cycle vector strobe, the bad-address register being untouched outside address errors, and reserved bits staying zero. The bench's scenarios are needed for the rest, because a property can only restate those values. This covers the complete code table, the four vector values from base and offset combinations, and the mask applied to software writes. It also covers a software write being discarded when it collides with a request.

// File: rtl/cp0_exc_entry.sv
module cp0_exc_entry #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [XLEN-1:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
  parameter logic [11:0] REFILL_OFF = 12'h080,
  parameter logic [11:0] GEN_OFF = 12'h180,
  parameter logic [31:0] CAUSE_MASK = 32'hB0C0_FF7C,
  parameter logic [31:0] STATUS_MASK = 32'hF040_FFFF,
  parameter logic [31:0] STATUS_RST = 32'h0040_0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [3:0]      exc_cause,
  input  logic [XLEN-1:0] exc_pc,
  input  logic            exc_in_delay,
  input  logic [XLEN-1:0] exc_badaddr,
  input  logic            sw_we_cause,
  input  logic            sw_we_status,
  input  logic [31:0]     sw_wdata,
  output logic [31:0]     cause_q,
  output logic [31:0]     status_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badvaddr_q,
  output logic [XLEN-1:0] vec_pc,
  output logic            vec_valid
);
  localparam int EXL = 1;
  localparam int BEV = 22;
  localparam int BD  = 31;

  logic [4:0] code;
  always_comb begin
    case (exc_cause)
      4'd0:  code = 5'h00;
      4'd1:  code = 5'h01;
      4'd2:  code = 5'h02;
      4'd3:  code = 5'h03;
      4'd4:  code = 5'h04;
      4'd5:  code = 5'h05;
      4'd6:  code = 5'h08;
      4'd7:  code = 5'h09;
      4'd8:  code = 5'h0A;
      4'd9:  code = 5'h0B;
      4'd10: code = 5'h0C;
      4'd11: code = 5'h0D;
      4'd12: code = 5'h12;
      4'd13: code = 5'h02;
      4'd14: code = 5'h03;
      default: code = 5'h0A;
    endcase
  end

  wire nested   = status_q[EXL];
  wire refill   = (exc_cause == 4'd13) || (exc_cause == 4'd14);
  wire addr_err = (exc_cause == 4'd4) || (exc_cause == 4'd5);
  wire [11:0] off = (refill && !nested) ? REFILL_OFF : GEN_OFF;
  wire [XLEN-1:0] base = status_q[BEV] ? BOOT_BASE : NORM_BASE;
  wire [XLEN-1:0] target = base + {{(XLEN-12){off[11]}}, off};
  wire [XLEN-1:0] ret_pc = exc_in_delay ? exc_pc - XLEN'(4) : exc_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q    <= '0;
      status_q   <= STATUS_RST;
      epc_q      <= '0;
      badvaddr_q <= '0;
      vec_pc     <= '0;
      vec_valid  <= 1'b0;
    end else begin
      vec_valid <= exc_req;
      if (exc_req) begin
        if (!nested) begin
          epc_q       <= ret_pc;
          cause_q[BD] <= exc_in_delay;
        end
        cause_q[6:2]    <= code;
        status_q[EXL]   <= 1'b1;
        vec_pc          <= target;
        if (addr_err) badvaddr_q <= exc_badaddr;
      end else begin
        if (sw_we_cause)  cause_q  <= sw_wdata & CAUSE_MASK;
        if (sw_we_status) status_q <= sw_wdata & STATUS_MASK;
      end
    end
  end
endmodule

module cp0_exc_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic [3:0]      exc_cause,
  input logic [XLEN-1:0] exc_pc,
  input logic            exc_in_delay,
  input logic [31:0]     cause_q,
  input logic [31:0]     status_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] badvaddr_q,
  input logic            vec_valid
);
  a_r5_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> status_q[1]);
  a_r5_other_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (status_q & ~32'h2) == ($past(status_q) & ~32'h2));
  a_r4_nested_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && status_q[1]) |=> ($stable(epc_q) && cause_q[31] == $past(cause_q[31])));
  a_r3_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !status_q[1] && exc_in_delay) |=> (cause_q[31] && epc_q == $past(exc_pc) - XLEN'(4)));
  a_r7_vec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (vec_valid == $past(exc_req)));
  a_r8_badv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && (exc_cause == 4'd4 || exc_cause == 4'd5)) |=> $stable(badvaddr_q));
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~32'hB0C0_FF7C) == 32'h0) && ((status_q & ~32'hF040_FFFF) == 32'h0));
endmodule

bind cp0_exc_entry cp0_exc_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/cp0_exc_entry_bench.sv
`timescale 1ns/1ps
module cp0_exc_entry_bench;
  logic clk = 0, rst_n = 0;
  logic exc_req = 0, exc_in_delay = 0, sw_we_cause = 0, sw_we_status = 0;
  logic [3:0] exc_cause = 0;
  logic [63:0] exc_pc = 0, exc_badaddr = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] cause_q, status_q;
  logic [63:0] epc_q, badvaddr_q, vec_pc;
  logic vec_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_cause, m_status;
  logic [63:0] m_epc, m_badv, m_vec;
  bit m_valid;

  always #2 clk = ~clk;

  cp0_exc_entry u_cp0_exc_entry (.*);

  function automatic logic [4:0] exp_code(input int c);
    int tbl[16] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 18, 2, 3, 10};
    return 5'(tbl[c]);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_cause = 0; m_status = 32'h0040_0004; m_epc = 0; m_badv = 0; m_vec = 0; m_valid = 0;
    end else begin
      m_valid = exc_req;
      if (exc_req) begin
        longint unsigned b, o;
        b = m_status[22] ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
        o = ((exc_cause == 13 || exc_cause == 14) && !m_status[1]) ? 64'h80 : 64'h180;
        m_vec = b + o;
        if (!m_status[1]) begin
          m_epc = exc_in_delay ? exc_pc - 4 : exc_pc;
          m_cause[31] = exc_in_delay;
        end
        m_cause[6:2] = exp_code(int'(exc_cause));
        m_status[1] = 1;
        if (exc_cause == 4 || exc_cause == 5) m_badv = exc_badaddr;
      end else begin
        if (sw_we_cause) m_cause = sw_wdata & 32'hB0C0_FF7C;
        if (sw_we_status) m_status = sw_wdata & 32'hF040_FFFF;
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 cause", 64'(cause_q), 64'(m_cause));
    check("R5 status", 64'(status_q), 64'(m_status));
    check("R3 epc", epc_q, m_epc);
    check("R8 badvaddr", badvaddr_q, m_badv);
    check("R6 vector", vec_pc, m_vec);
    check("R7 vec_valid", 64'(vec_valid), 64'(m_valid));
    exc_req = 0; sw_we_cause = 0; sw_we_status = 0;
  endtask

  task automatic take(input int c, input logic [63:0] pc, input bit dly, input logic [63:0] ba);
    exc_req = 1; exc_cause = 4'(c); exc_pc = pc; exc_in_delay = dly; exc_badaddr = ba;
    cycle();
  endtask

  task automatic sw_status(input logic [31:0] d);
    sw_we_status = 1; sw_wdata = d;
    cycle();
  endtask

  initial begin
    @(negedge clk);
    cycle(); cycle();
    rst_n = 1;
    check("R1 status reset", 64'(status_q), 64'h0040_0004);
    check("R1 cause reset", 64'(cause_q), 64'h0);
    check("R1 valid reset", 64'(vec_valid), 64'h0);
    cycle();
    take(13, 64'h1000, 0, 0);
    check("R6 refill vector boot", vec_pc, 64'hFFFF_FFFF_BFC0_0280);
    cycle();
    check("R7 valid one cycle", 64'(vec_valid), 64'h0);
    take(6, 64'h2000, 1, 0);
    check("R4 epc held nested", epc_q, 64'h1000);
    check("R4 bd held nested", 64'(cause_q[31]), 64'h0);
    check("R4 code updated nested", 64'(cause_q[6:2]), 64'h08);
    take(14, 64'h2100, 0, 0);
    check("R6 refill nested uses 0x180", vec_pc, 64'hFFFF_FFFF_BFC0_0380);
    sw_status(32'hFFFF_FF00);
    check("R9 status mask", 64'(status_q), 64'hF040_FF00);
    sw_status(32'h0000_0000);
    for (int c = 0; c < 16; c++) begin
      take(c, 64'h4000 + 64'(c * 16), c[0], 64'hDEAD_0000 + 64'(c));
      check("R2 code", 64'(cause_q[6:2]), 64'(exp_code(c)));
      sw_status(32'h0000_0000);
    end
    take(14, 64'h5000, 0, 0);
    check("R6 R7 refill normal base", vec_pc, 64'hFFFF_FFFF_8000_0080);
    sw_status(32'h0000_0000);
    take(5, 64'h6000, 1, 64'h0123_4567_89AB_CDEF);
    check("R8 badvaddr load", badvaddr_q, 64'h0123_4567_89AB_CDEF);
    check("R3 delay epc", epc_q, 64'h5FFC);
    check("R3 delay bd", 64'(cause_q[31]), 64'h1);
    sw_status(32'h0000_0000);
    take(10, 64'h7000, 0, 64'h1111);
    check("R8 badvaddr kept", badvaddr_q, 64'h0123_4567_89AB_CDEF);
    check("R3 plain epc", epc_q, 64'h7000);
    check("R7 normal general vector", vec_pc, 64'hFFFF_FFFF_8000_0180);
    sw_we_cause = 1; sw_wdata = 32'hFFFF_FFFF;
    cycle();
    check("R9 cause mask", 64'(cause_q), 64'hB0C0_FF7C);
    sw_status(32'h0040_0000);
    sw_we_status = 1; sw_we_cause = 1; sw_wdata = 32'h0;
    exc_req = 1; exc_cause = 4'd7; exc_pc = 64'h8000; exc_in_delay = 0;
    cycle();
    check("R10 status write dropped", 64'(status_q), 64'h0040_0002);
    check("R10 cause write dropped", 64'(cause_q), 64'(32'hB0C0_FF7C & ~32'h8000_007C | 32'h0000_0024));
    repeat (3) cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule